// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a matrix of 64 switches arranged as eight column strobes and eight row sense lines. While no key is down it keeps all eight strobes on, so one sample of the rows shows whether any switch is closed. Samples are taken only on a prescaler tick. When a tick sees a non-zero row value, the block strobes the columns one at a time, starting at column 0, until it finds one with row activity.

The key in that column is read again on the following tick. If it reads the same both times, the block latches a 6-bit key code, sets a valid flag and raises a level interrupt. A read-acknowledge pulse clears the flag and the interrupt. After a report the block goes back to all-on polling. It does not report again until the rows have read all-zero on at least one tick.

Top module: `keypad_scan`

## Requirements
- R1: After reset, `cols` is 8'hFF, `key_valid` and `irq` are 0 and `key_code` is 0.
- R2: While idle, all eight column strobes are driven high together.
- R3: Rows are sampled only on a tick, which is the last cycle of every `SAMPLE_DIV`-cycle period. Row activity that starts and ends between two ticks has no effect on any output.
- R4: A tick that sees non-zero rows while idle and armed starts a scan. The scan drives the one-hot value `1 << c` on `cols`, with c starting at 0 and going up by one on each tick that reads all-zero rows.
- R5: The key code is {column index[2:0], row index[2:0]}. Column index c is the strobe `cols[c]` and row index r is `rows[r]`. The code uses the lowest active row of the first column that shows activity.
- R6: A key is reported only if the next tick, with the same column still driven, sees the same lowest active row. If it does not, the block returns to idle without reporting.
- R7: After a report the block drives all columns again. A key that is still held is not reported again until a tick has read 8'h00 on the rows.
- R8: A high `ack` clears `key_valid` and `irq` on the next edge. If a report happens on the same edge, the report wins.
- R9: If the scan passes column 7 without finding activity, the block returns to idle with no report.
- R10: `irq` always equals `key_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rows | input | 8 | Row sense lines, high when a switch on a driven column is closed |
| ack | input | 1 | Read acknowledge, clears the valid flag and the interrupt |
| cols | output | 8 | Column strobes, active high |
| key_code | output | 6 | Latched key code {column, row} |
| key_valid | output | 1 | A key code is waiting to be read |
| irq | output | 1 | Interrupt request |

## Verification
Single keys placed in the first, a middle and the last column show whether the scan order and the code fields are right. Two keys in one column check that the lowest row is chosen. Two keys in different columns check that the first column wins. A key released just after the scan starts, and one released between its two matching samples, separate the end-of-scan path from the debounce reject path. A pulse that falls wholly between ticks shows that sampling is tied to the prescaler. Holding a key across an acknowledge, and holding `ack` high during a press, exercise the re-arm rule and the priority of a report over a clear.

// File: rtl/keypad_scan.sv
module keypad_scan #(
  parameter int SAMPLE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rows,
  input  logic       ack,
  output logic [7:0] cols,
  output logic [5:0] key_code,
  output logic       key_valid,
  output logic       irq
);
  localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  typedef enum logic [1:0] {IDLE, SCAN, CONFIRM} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        tick;
  logic [2:0]  col;
  logic [2:0]  cand;
  logic [2:0]  low;
  logic        armed;
  logic        any;

  assign tick = (cnt == CW'(SAMPLE_DIV - 1));
  assign any  = |rows;
  assign cols = (st == IDLE) ? 8'hFF : (8'd1 << col);
  assign irq  = key_valid;

  always_comb begin
    low = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (rows[i]) low = 3'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      col       <= 3'd0;
      cand      <= 3'd0;
      armed     <= 1'b1;
      key_code  <= 6'd0;
      key_valid <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (ack) key_valid <= 1'b0;
      if (tick) begin
        case (st)
          IDLE: begin
            if (!any) armed <= 1'b1;
            else if (armed) begin
              st  <= SCAN;
              col <= 3'd0;
            end
          end
          SCAN: begin
            if (any) begin
              cand <= low;
              st   <= CONFIRM;
            end else if (col == 3'd7) begin
              st <= IDLE;
            end else begin
              col <= col + 3'd1;
            end
          end
          default: begin
            st <= IDLE;
            if (any && low == cand) begin
              key_code  <= {col, cand};
              key_valid <= 1'b1;
              armed     <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

module keypad_scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ack,
  input logic [7:0] cols,
  input logic [5:0] key_code,
  input logic       key_valid,
  input logic       irq
);
  a_r4_cols_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (cols == 8'hFF) || $onehot(cols));

  a_r3_cols_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cols) |-> $past(tick));

  a_r5_code_matches_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> ($past(cols) == (8'd1 << key_code[5:3])));

  a_r7_idle_after_report: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> (cols == 8'hFF));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!key_valid || (cols == 8'hFF && $past(cols) != 8'hFF)));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == key_valid);
endmodule

bind keypad_scan keypad_scan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ack(ack), .cols(cols),
  .key_code(key_code), .key_valid(key_valid), .irq(irq)
);

// File: tb/keypad_scan_test.sv
module keypad_scan_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0;
  logic [7:0] rows;
  logic [7:0] cols;
  logic [5:0] key_code;
  logic key_valid;
  logic irq;
  logic [63:0] pressed = '0;

  int compared = 0;
  int mismatched = 0;

  int m_st, m_cnt, m_col, m_cand, m_armed, m_code, m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_scan #(.SAMPLE_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .rows(rows), .ack(ack), .cols(cols),
    .key_code(key_code), .key_valid(key_valid), .irq(irq)
  );

  always_comb begin
    rows = 8'h00;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++)
        if (cols[c] && pressed[c*8+r]) rows[r] = 1'b1;
  end

  function automatic int m_cols();
    return (m_st == 0) ? 8'hFF : (1 << m_col);
  endfunction

  always @(posedge clk) begin
    int rv, lo;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_col = 0; m_cand = 0;
      m_armed = 1; m_code = 0; m_valid = 0;
    end else begin
      rv = rows;
      lo = 0;
      for (int i = 7; i >= 0; i--) if (rv[i]) lo = i;
      if (ack) m_valid = 0;
      if (m_cnt == DIV - 1) begin
        m_cnt = 0;
        if (m_st == 0) begin
          if (rv == 0) m_armed = 1;
          else if (m_armed == 1) begin m_st = 1; m_col = 0; end
        end else if (m_st == 1) begin
          if (rv != 0) begin m_cand = lo; m_st = 2; end
          else if (m_col == 7) m_st = 0;
          else m_col = m_col + 1;
        end else begin
          m_st = 0;
          if (rv != 0 && lo == m_cand) begin
            m_code = m_col * 8 + m_cand; m_valid = 1; m_armed = 0;
          end
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cols == 8'(m_cols()), "R4 cols vs model", cols, m_cols());
      check(key_code == 6'(m_code), "R5 key_code vs model", key_code, m_code);
      check(key_valid == 1'(m_valid), "R6 key_valid vs model", key_valid, m_valid);
      check(irq == key_valid, "R10 irq level", irq, key_valid);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key(input int c, input int r, input bit v);
    pressed[c*8+r] = v;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic expect_key(input int code, input string tag);
    check(key_valid == 1'b1, tag, key_valid, 1);
    check(key_code == 6'(code), tag, key_code, code);
    check(cols == 8'hFF, tag, cols, 8'hFF);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check(cols == 8'hFF && !key_valid && !irq && key_code == 0, "R1 reset state",
          {cols, key_valid, key_code}, {8'hFF, 1'b0, 6'd0});
    cyc(20);
    check(cols == 8'hFF, "R2 idle all columns on", cols, 8'hFF);

    key(3, 5, 1); cyc(60);
    expect_key(6'h1D, "R5 single key col3 row5");
    cyc(40);
    expect_key(6'h1D, "R7 held key no re-report");
    pulse_ack();
    check(!key_valid && !irq, "R8 ack clears", {key_valid, irq}, 0);
    cyc(40);
    check(!key_valid, "R7 held key stays silent after ack", key_valid, 0);
    key(3, 5, 0); cyc(20);

    key(0, 2, 1); key(0, 6, 1); cyc(60);
    expect_key(6'h02, "R5 lowest row in column 0");
    pulse_ack(); key(0, 2, 0); key(0, 6, 0); cyc(20);

    key(5, 1, 1); key(2, 7, 1); cyc(60);
    expect_key(6'h17, "R4 first active column wins");
    pulse_ack(); key(5, 1, 0); key(2, 7, 0); cyc(20);

    key(7, 7, 1); cyc(60);
    expect_key(6'h3F, "R4 last column reached");
    pulse_ack(); key(7, 7, 0); cyc(20);

    key(7, 0, 1);
    while (cols == 8'hFF) cyc(1);
    key(7, 0, 0); cyc(60);
    check(!key_valid && cols == 8'hFF, "R9 scan runs out, no report", key_valid, 0);

    key(4, 3, 1);
    while (cols != 8'h10) cyc(1);
    cyc(5);
    key(4, 3, 0); cyc(30);
    check(!key_valid, "R6 bounce rejected", key_valid, 0);
    check(cols == 8'hFF, "R6 back to idle after reject", cols, 8'hFF);

    while (m_cnt != 0) cyc(1);
    key(6, 6, 1); cyc(2); key(6, 6, 0); cyc(20);
    check(!key_valid && cols == 8'hFF, "R3 pulse between ticks ignored", key_valid, 0);

    ack = 1'b1;
    key(1, 4, 1); cyc(60);
    check(!key_valid, "R8 held ack keeps flag low", key_valid, 0);
    ack = 1'b0; key(1, 4, 0); cyc(20);

    key(6, 0, 1); cyc(60);
    expect_key(6'h30, "R7 re-armed after release");
    key(6, 0, 0); cyc(10);

    finish_run();
  end
endmodule